// File: doc/BRIEF.md
# PLL Clock Mode Controller

This block is the synchronous decision logic that sits beside an analog PLL and chooses the source of the CPU clock. The choice is among the reference clock halved, the undivided reference, the PLL output, and a slow fallback clock used when the reference is lost. It holds three pieces of configuration: a 4-bit PLL multiplier, an undivided-reference select bit, and a PLL power-down bit. Software writes them through a small write port, and only while a write-protect release flag is high. The block drives the multiplier and the power-down line to the PLL. It also drives a 2-bit select code to an external glitch-free clock mux. The PLL, the oscillator and the mux are outside this block.

Ordering rules guard the configuration. The undivided-reference bit and the power-down bit may be set only while the multiplier is zero. The multiplier may not be written once the undivided bit is set. Writes that break a rule, and writes of a reserved multiplier code, are dropped and raise a sticky error flag. After every accepted multiplier write, the clock stays on the bypass source until the PLL reports lock. The clock also returns to bypass if lock is lost.

The fallback to the slow clock arms only after the reference has been seen present once since reset. The lock input and the reference-present input are asynchronous. Each passes through a two-flop synchronizer before any decision uses it. All pins are plain control and status levels. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the multiplier is 0, the undivided and power-down bits are 0, the error and slow-clock flags are 0, and `src_sel` is 0 (reference/2).
- R2: Writes while `prot_en` is low change no configuration and raise no error.
- R3: Writing `wr_addr`=0 stores `wr_data` as the multiplier when it is 0 to 10. Codes 11 to 15 are dropped and set the error flag.
- R4: A multiplier write is dropped and sets the error flag when the undivided bit is 1, or when the power-down bit is 1 and the written code is non-zero.
- R5: A write to `wr_addr`=1 sets the undivided bit from `wr_data[0]` and the power-down bit from `wr_data[1]`. If either written bit is 1 while the multiplier is non-zero, the write is dropped and sets the error flag.
- R6: The error flag stays set until reset.
- R7: With the multiplier at 0, or the PLL powered down, `src_sel` is 1 (reference) when the undivided bit is 1 and 0 (reference/2) when it is 0.
- R8: After an accepted non-zero multiplier write, `st_locking` is 1 and `src_sel` stays at bypass until the synchronized lock is high. The following edge sets `src_sel` to 2 (PLL).
- R9: If the synchronized lock falls while `src_sel` is 2, the block returns to bypass with `st_locking` high.
- R10: `pll_mult` always equals the stored multiplier, and `pll_pd` equals the stored power-down bit.
- R11: Once the synchronized reference-present flag has been high at least once since reset, a low value with the PLL not powered down gives `src_sel` = 3 (slow clock). Before that first sighting, reference loss has no effect.
- R12: `st_limp` is set whenever the slow clock is selected and stays set until reset, even after the reference returns.
- R13: A change on `pll_lock_a` or `ref_ok_a` reaches the decision logic through exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_en | input | 1 | Write-protect release; writes count only while high |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 1 | 0 = multiplier, 1 = control bits |
| wr_data | input | 4 | Write data |
| pll_lock_a | input | 1 | Asynchronous PLL lock flag |
| ref_ok_a | input | 1 | Asynchronous reference-present flag |
| src_sel | output | 2 | 0 ref/2, 1 ref, 2 PLL, 3 slow clock |
| pll_mult | output | 4 | Multiplier sent to the PLL |
| pll_pd | output | 1 | PLL power-down |
| st_div | output | 1 | Stored undivided-reference bit |
| st_locking | output | 1 | Waiting for lock |
| st_limp | output | 1 | Sticky slow-clock flag |
| st_err | output | 1 | Sticky illegal-write flag |

## Verification
The assertions check invariants on every cycle:
- the stored multiplier is always legal;
- the undivided and power-down bits never coexist with a non-zero multiplier;
- configuration holds while protection is active;
- the sticky flags never clear;
- the PLL source is entered only after a synchronized lock.

Only the bench scenarios show the exact cycle counts through the synchronizers. The same holds for the arming of the fallback after the first reference sighting and the return to bypass on lock loss. A cycle-by-cycle model compares all outputs on every clock across these sequences.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  typedef enum logic [1:0] {
    SRC_REF_HALF = 2'd0,
    SRC_REF      = 2'd1,
    SRC_PLL      = 2'd2,
    SRC_LIMP     = 2'd3
  } clk_src_e;

  localparam logic ADDR_MULT   = 1'b0;
  localparam logic ADDR_CTRL   = 1'b1;
  localparam int   CTRL_DIV_BIT = 0;
  localparam int   CTRL_OFF_BIT = 1;
endpackage

// File: rtl/clkmode_sync.sv
module clkmode_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/clkmode_cfg.sv
module clkmode_cfg
  import clkmode_pkg::*;
#(
  parameter int MULT_W   = 4,
  parameter int MULT_MAX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_en,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [MULT_W-1:0] wr_data,
  output logic [MULT_W-1:0] mult_q,
  output logic              div_q,
  output logic              off_q,
  output logic              err_q,
  output logic              mult_load
);
  localparam logic [MULT_W-1:0] MAX_CODE = MULT_W'(MULT_MAX);

  logic mult_wr, ctl_wr, mult_bad, ctl_bad, ctl_load, mult_nz;

  assign mult_nz  = (mult_q != '0);
  assign mult_wr  = wr_en && prot_en && (wr_addr == ADDR_MULT);
  assign ctl_wr   = wr_en && prot_en && (wr_addr == ADDR_CTRL);
  assign mult_bad = (wr_data > MAX_CODE) || div_q || (off_q && (wr_data != '0));
  assign ctl_bad  = mult_nz && (wr_data[CTRL_DIV_BIT] || wr_data[CTRL_OFF_BIT]);
  assign mult_load = mult_wr && !mult_bad;
  assign ctl_load  = ctl_wr && !ctl_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= '0;
      div_q  <= 1'b0;
      off_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (mult_load) mult_q <= wr_data;
      if (ctl_load) begin
        div_q <= wr_data[CTRL_DIV_BIT];
        off_q <= wr_data[CTRL_OFF_BIT];
      end
      if ((mult_wr && mult_bad) || (ctl_wr && ctl_bad)) err_q <= 1'b1;
    end
  end

  p_mult_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mult_q <= MAX_CODE);
  p_div_needs_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q || off_q) |-> !mult_nz);
  p_protect_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |=> $stable({mult_q, div_q, off_q, err_q}));
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/clkmode_sel.sv
module clkmode_sel
  import clkmode_pkg::*;
#(
  parameter int MULT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MULT_W-1:0] mult_q,
  input  logic              div_q,
  input  logic              off_q,
  input  logic              mult_load,
  input  logic              lock_s,
  input  logic              ref_s,
  output clk_src_e          src,
  output logic              locking,
  output logic              limp_st
);
  logic run_q, seen_q, limp_now, mult_nz;

  assign mult_nz  = (mult_q != '0);
  assign limp_now = seen_q && !ref_s && !off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      seen_q  <= 1'b0;
      limp_st <= 1'b0;
    end else begin
      if (mult_load || !mult_nz) run_q <= 1'b0;
      else if (!run_q && lock_s) run_q <= 1'b1;
      else if (run_q && !lock_s) run_q <= 1'b0;
      seen_q  <= seen_q || ref_s;
      limp_st <= limp_st || limp_now;
    end
  end

  always_comb begin
    if (limp_now)   src = SRC_LIMP;
    else if (run_q) src = SRC_PLL;
    else if (div_q) src = SRC_REF;
    else            src = SRC_REF_HALF;
  end

  assign locking = mult_nz && !run_q;

  p_run_after_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(lock_s));
  p_lock_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !lock_s && !mult_load) |=> !run_q);
  p_limp_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    limp_st |=> limp_st);
  p_limp_armed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_LIMP) |-> seen_q);
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int MULT_W      = 4,
  parameter int MULT_MAX    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_en,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [MULT_W-1:0] wr_data,
  input  logic              pll_lock_a,
  input  logic              ref_ok_a,
  output logic [1:0]        src_sel,
  output logic [MULT_W-1:0] pll_mult,
  output logic              pll_pd,
  output logic              st_div,
  output logic              st_locking,
  output logic              st_limp,
  output logic              st_err
);
  logic [1:0]        sync_q;
  logic [MULT_W-1:0] mult_q;
  logic              div_q, off_q, mult_load;
  clk_src_e          src;

  clkmode_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ref_ok_a, pll_lock_a}), .q(sync_q)
  );

  clkmode_cfg #(.MULT_W(MULT_W), .MULT_MAX(MULT_MAX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .mult_q(mult_q), .div_q(div_q),
    .off_q(off_q), .err_q(st_err), .mult_load(mult_load)
  );

  clkmode_sel #(.MULT_W(MULT_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .mult_q(mult_q), .div_q(div_q), .off_q(off_q),
    .mult_load(mult_load), .lock_s(sync_q[0]), .ref_s(sync_q[1]),
    .src(src), .locking(st_locking), .limp_st(st_limp)
  );

  assign src_sel  = src;
  assign pll_mult = mult_q;
  assign pll_pd   = off_q;
  assign st_div   = div_q;

  p_pll_needs_mult_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd2) |-> (pll_mult != '0 && !pll_pd));
endmodule

// File: tb/clkmode_ctrl_tb_top.sv
module clkmode_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prot_en = 1'b0, wr_en = 1'b0, wr_addr = 1'b0;
  logic [3:0] wr_data = '0;
  logic pll_lock_a = 1'b0, ref_ok_a = 1'b0;
  logic [1:0] src_sel;
  logic [3:0] pll_mult;
  logic pll_pd, st_div, st_locking, st_limp, st_err;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  clkmode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pll_lock_a(pll_lock_a),
    .ref_ok_a(ref_ok_a), .src_sel(src_sel), .pll_mult(pll_mult),
    .pll_pd(pll_pd), .st_div(st_div), .st_locking(st_locking),
    .st_limp(st_limp), .st_err(st_err)
  );

  // behavioural reference model
  int m_mult; bit m_div, m_off, m_err, m_run, m_seen, m_limp;
  bit lk0, lk1, rf0, rf1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mult = 0; m_div = 0; m_off = 0; m_err = 0; m_run = 0;
      m_seen = 0; m_limp = 0; lk0 = 0; lk1 = 0; rf0 = 0; rf1 = 0;
    end else begin
      bit ld, nrun, ldiv, loff, cld; int nm;
      ld = 0; cld = 0; nm = m_mult; ldiv = m_div; loff = m_off;
      if (wr_en && prot_en) begin
        if (wr_addr == 1'b0) begin
          if (wr_data > 10 || m_div || (m_off && wr_data != 0)) m_err = 1;
          else begin ld = 1; nm = wr_data; end
        end else begin
          if (m_mult != 0 && (wr_data[0] || wr_data[1])) m_err = 1;
          else begin cld = 1; ldiv = wr_data[0]; loff = wr_data[1]; end
        end
      end
      nrun = m_run;
      if (ld || m_mult == 0) nrun = 0;
      else if (!m_run && lk1) nrun = 1;
      else if (m_run && !lk1) nrun = 0;
      if (m_seen && !rf1 && !m_off) m_limp = 1;
      m_seen = m_seen || rf1;
      m_run = nrun; m_mult = nm;
      if (cld) begin m_div = ldiv; m_off = loff; end
      lk1 = lk0; lk0 = pll_lock_a; rf1 = rf0; rf0 = ref_ok_a;
    end
  end

  task automatic cmp(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int esrc;
      if (m_seen && !rf1 && !m_off) esrc = 3;
      else if (m_run) esrc = 2;
      else if (m_div) esrc = 1;
      else esrc = 0;
      cmp("R7 R8 R9 R11 R13 src_sel", src_sel, esrc);
      cmp("R3 R10 pll_mult", pll_mult, m_mult);
      cmp("R10 pll_pd", pll_pd, m_off);
      cmp("R5 st_div", st_div, m_div);
      cmp("R8 R9 st_locking", st_locking, (m_mult != 0) && !m_run);
      cmp("R12 st_limp", st_limp, m_limp);
      cmp("R6 st_err", st_err, m_err);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(bit a, logic [3:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    #1;
  endtask

  task automatic do_reset(bit ref_on);
    @(negedge clk);
    rst_n = 0; ref_ok_a = ref_on; pll_lock_a = 0; prot_en = 1;
    cyc(2);
    rst_n = 1;
    cyc(3);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(2); rst_n = 1; #1;
    cmp("R1 src", src_sel, 0); cmp("R1 mult", pll_mult, 0);
    cmp("R1 err", st_err, 0); cmp("R1 limp", st_limp, 0);
    ref_ok_a = 1; cyc(3);
    // R2: protected write ignored
    prot_en = 0; wr(1'b1, 4'b0001);
    cmp("R2 div ignored", st_div, 0); cmp("R2 no err", st_err, 0);
    wr(1'b0, 4'd4); cmp("R2 mult ignored", pll_mult, 0);
    prot_en = 1;
    // R3: reserved code
    wr(1'b0, 4'd11); cmp("R3 reserved err", st_err, 1); cmp("R3 mult kept", pll_mult, 0);
    wr(1'b0, 4'd10); cmp("R3 max accepted", pll_mult, 10);
    cyc(2); cmp("R6 err sticky", st_err, 1);

    // R8 / R13 lock sequence
    do_reset(1);
    wr(1'b0, 4'd5);
    cmp("R8 locking", st_locking, 1); cmp("R8 bypass", src_sel, 0);
    cmp("R10 mult out", pll_mult, 5);
    pll_lock_a = 1;
    cyc(2); cmp("R13 lock after two edges still bypass", src_sel, 0);
    cyc(1); cmp("R8 pll selected", src_sel, 2); cmp("R8 locked", st_locking, 0);
    wr(1'b1, 4'b0001); cmp("R5 div rejected", st_div, 0); cmp("R5 err", st_err, 1);
    // R9 lock loss
    pll_lock_a = 0; cyc(3);
    cmp("R9 back to bypass", src_sel, 0); cmp("R9 locking", st_locking, 1);
    pll_lock_a = 1; cyc(4); cmp("R9 relock", src_sel, 2);
    wr(1'b0, 4'd7); cmp("R8 rewrite forces bypass", src_sel, 0);
    cyc(4); cmp("R8 relock after rewrite", src_sel, 2);

    // R7 / R4 undivided bit
    do_reset(1);
    wr(1'b1, 4'b0001); cmp("R7 undivided ref", src_sel, 1);
    wr(1'b0, 4'd3); cmp("R4 mult rejected div", pll_mult, 0); cmp("R4 err", st_err, 1);

    // R10 / R4 power-down
    do_reset(1);
    wr(1'b1, 4'b0010); cmp("R10 pd", pll_pd, 1); cmp("R7 off ref/2", src_sel, 0);
    wr(1'b0, 4'd2); cmp("R4 mult rejected off", pll_mult, 0); cmp("R4 err off", st_err, 1);
    ref_ok_a = 0; cyc(3); cmp("R11 no limp when off", src_sel, 0);

    // R11 / R12 / R13 slow-clock fallback
    do_reset(0);
    cyc(4); cmp("R11 unarmed", src_sel, 0); cmp("R11 limp flag clear", st_limp, 0);
    ref_ok_a = 1; cyc(4);
    ref_ok_a = 0;
    cyc(1); cmp("R13 one edge no limp", src_sel, 0);
    cyc(1); cmp("R11 limp selected", src_sel, 3);
    cyc(1); cmp("R12 limp flag", st_limp, 1);
    ref_ok_a = 1; cyc(3);
    cmp("R11 ref back", src_sel, 0); cmp("R12 limp sticky", st_limp, 1);

    cyc(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule